// File: doc/BRIEF.md
# Double-Precision NaN Classifier and Quieter

This block inspects one 64-bit IEEE 754 double-precision operand and reports which of six categories it falls into: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. A run-time mode pin selects which NaN encoding is in force. In 2008-style mode, a NaN whose most significant fraction bit is clear is signaling. In legacy mode, the polarity is reversed and a set top fraction bit marks a signaling NaN.

When the quiet request pin is high and the operand is a signaling NaN, the block produces a quieted value and raises an invalid-operation flag. In 2008-style mode, the quieted value is the operand with its top fraction bit forced to one, so the sign and the rest of the payload survive. In legacy mode, the whole operand is replaced by a fixed default NaN. Any other operand goes through to the result word untouched.

The block is purely combinational and has no clock, so it carries no flow control. Every output settles from the present inputs, and there is no back-pressure to honour. It is meant to sit in front of floating-point arithmetic, which consumes the class code and the quieted word.

Top module: `dpnan_classify_quiet`

## Requirements
- R1: An operand with exponent field (bits 62:52) equal to 0 and fraction (bits 51:0) equal to 0 is classed 3'd0 (zero), for either sign.
- R2: An operand with exponent field 0 and a nonzero fraction is classed 3'd1 (subnormal).
- R3: An operand whose exponent field is neither 0 nor 11'h7FF is classed 3'd2 (normal), whatever its fraction and sign.
- R4: An operand with exponent field 11'h7FF and a zero fraction is classed 3'd3 (infinity).
- R5: An operand with exponent field 11'h7FF and a nonzero fraction is a NaN. It is classed 3'd5 (signaling) when fraction bit 51 XOR the mode bit (1 = 2008-style) is 1, and 3'd4 (quiet) otherwise.
- R6: With quiet request high, a signaling NaN and the mode bit at 1, the result equals the operand with bit 51 set and every other bit unchanged.
- R7: With quiet request high, a signaling NaN and the mode bit at 0, the result is 64'h7FF7_FFFF_FFFF_FFFF.
- R8: The invalid flag is 1 exactly when quiet request is high and the operand is classed signaling NaN.
- R9: In every case not covered by R6 or R7, the result equals the operand.
- R10: The class output does not depend on the quiet request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 64 | Double-precision operand |
| mode2008_i | input | 1 | 1 = 2008-style NaN encoding, 0 = legacy encoding |
| quiet_req_i | input | 1 | Ask for a signaling NaN to be quieted |
| class_o | output | 3 | Class code: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN |
| result_o | output | 64 | Quieted operand or the unchanged operand |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The bench goes after the single fraction bit that decides signaling against quiet, in both modes:
- NaNs whose only set fraction bit is bit 51.
- NaNs whose bit 51 is clear but with a payload below it.
A design that ignored the mode, or inverted it, would swap the quiet and signaling codes and raise the invalid flag on quiet NaNs.

The bench also probes the boundary exponents 0 and 11'h7FF with the smallest and largest fractions. An off-by-one decode there would class infinity as a NaN or a subnormal as zero.

The quieting checks compare the whole result word, including the sign and low payload bits. Any of the following would therefore show up:
- a 2008-style quieter that clears the payload;
- a legacy quieter that keeps the sign;
- a pass-through that alters a quiet NaN.

// File: rtl/dpnan_pkg.sv
package dpnan_pkg;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_class_e;
endpackage

// File: rtl/dpnan_field_decode.sv
module dpnan_field_decode #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              exp_zero_o,
  output logic              exp_ones_o,
  output logic              frac_zero_o,
  output logic              frac_msb_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f       = word_i[WORD_W-2 -: EXP_W];
  assign frac_f      = word_i[FRAC_W-1:0];
  assign exp_zero_o  = (exp_f == '0);
  assign exp_ones_o  = &exp_f;
  assign frac_zero_o = (frac_f == '0);
  assign frac_msb_o  = frac_f[FRAC_W-1];
endmodule

// File: rtl/dpnan_classifier.sv
module dpnan_classifier
  import dpnan_pkg::*;
(
  input  logic      exp_zero_i,
  input  logic      exp_ones_i,
  input  logic      frac_zero_i,
  input  logic      frac_msb_i,
  input  logic      mode2008_i,
  output fp_class_e class_o
);
  logic signal_bit;

  assign signal_bit = frac_msb_i ^ mode2008_i;

  always_comb begin
    if (exp_zero_i) begin
      class_o = frac_zero_i ? CLS_ZERO : CLS_SUB;
    end else if (!exp_ones_i) begin
      class_o = CLS_NORM;
    end else if (frac_zero_i) begin
      class_o = CLS_INF;
    end else begin
      class_o = signal_bit ? CLS_SNAN : CLS_QNAN;
    end
  end
endmodule

// File: rtl/dpnan_quieter.sv
module dpnan_quieter
  import dpnan_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  fp_class_e         class_i,
  input  logic              mode2008_i,
  input  logic              quiet_req_i,
  output logic [WORD_W-1:0] word_o,
  output logic              invalid_o
);
  localparam logic [WORD_W-1:0] LEGACY_DFLT =
    {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] QBIT_MASK =
    {{(WORD_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic do_quiet;

  assign do_quiet  = quiet_req_i && (class_i == CLS_SNAN);
  assign invalid_o = do_quiet;

  always_comb begin
    if (!do_quiet)       word_o = word_i;
    else if (mode2008_i) word_o = word_i | QBIT_MASK;
    else                 word_o = LEGACY_DFLT;
  end
endmodule

// File: rtl/dpnan_classify_quiet.sv
module dpnan_classify_quiet
  import dpnan_pkg::*;
(
  input  logic [63:0] opnd_i,
  input  logic        mode2008_i,
  input  logic        quiet_req_i,
  output logic [2:0]  class_o,
  output logic [63:0] result_o,
  output logic        invalid_o
);
  logic      exp_zero, exp_ones, frac_zero, frac_msb;
  fp_class_e cls;

  dpnan_field_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
    .word_i      (opnd_i),
    .exp_zero_o  (exp_zero),
    .exp_ones_o  (exp_ones),
    .frac_zero_o (frac_zero),
    .frac_msb_o  (frac_msb)
  );

  dpnan_classifier u_cls (
    .exp_zero_i  (exp_zero),
    .exp_ones_i  (exp_ones),
    .frac_zero_i (frac_zero),
    .frac_msb_i  (frac_msb),
    .mode2008_i  (mode2008_i),
    .class_o     (cls)
  );

  dpnan_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
    .word_i      (opnd_i),
    .class_i     (cls),
    .mode2008_i  (mode2008_i),
    .quiet_req_i (quiet_req_i),
    .word_o      (result_o),
    .invalid_o   (invalid_o)
  );

  assign class_o = cls;
endmodule

// File: rtl/dpnan_classify_quiet_chk.sv
module dpnan_classify_quiet_chk (
  input logic [63:0] opnd_i,
  input logic        mode2008_i,
  input logic        quiet_req_i,
  input logic [2:0]  class_o,
  input logic [63:0] result_o,
  input logic        invalid_o
);
  logic known;
  logic is_nan;

  assign known  = !$isunknown({opnd_i, mode2008_i, quiet_req_i});
  assign is_nan = (&opnd_i[62:52]) && (opnd_i[51:0] != 52'd0);

  always_comb begin
    if (known) begin
      // R5
      nan_class_chk: assert (!is_nan ||
        class_o == ((opnd_i[51] ^ mode2008_i) ? 3'd5 : 3'd4));
      // R8
      invalid_only_on_snan_chk: assert (invalid_o == (quiet_req_i && class_o == 3'd5));
      // R6
      q2008_payload_chk: assert (!(invalid_o && mode2008_i) ||
        result_o == (opnd_i | 64'h0008_0000_0000_0000));
      // R7
      legacy_default_chk: assert (!(invalid_o && !mode2008_i) ||
        result_o == 64'h7FF7_FFFF_FFFF_FFFF);
      // R9
      passthru_chk: assert (invalid_o || result_o == opnd_i);
      // R3
      normal_class_chk: assert (!(opnd_i[62:52] != 11'd0 && !(&opnd_i[62:52])) ||
        class_o == 3'd2);
    end
  end
endmodule

bind dpnan_classify_quiet dpnan_classify_quiet_chk u_chk (
  .opnd_i      (opnd_i),
  .mode2008_i  (mode2008_i),
  .quiet_req_i (quiet_req_i),
  .class_o     (class_o),
  .result_o    (result_o),
  .invalid_o   (invalid_o)
);

// File: tb/dpnan_classify_quiet_tb_top.sv
module dpnan_classify_quiet_tb_top;
  logic        clk = 1'b0;
  logic [63:0] opnd;
  logic        mode;
  logic        qreq;
  logic [2:0]  cls;
  logic [63:0] res;
  logic        inv;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  always #2 clk = ~clk;

  dpnan_classify_quiet dut_i (
    .opnd_i      (opnd),
    .mode2008_i  (mode),
    .quiet_req_i (qreq),
    .class_o     (cls),
    .result_o    (res),
    .invalid_o   (inv)
  );

  function automatic logic [2:0] exp_class(logic [63:0] x, logic m);
    logic [10:0] e = x[62:52];
    logic [51:0] f = x[51:0];
    if (e == 11'd0)      return (f == 52'd0) ? 3'd0 : 3'd1;
    if (e != 11'h7FF)    return 3'd2;
    if (f == 52'd0)      return 3'd3;
    return (x[51] ^ m) ? 3'd5 : 3'd4;
  endfunction

  function automatic logic [63:0] exp_result(logic [63:0] x, logic m, logic q);
    if (q && exp_class(x, m) == 3'd5)
      return m ? {x[63:52], 1'b1, x[50:0]} : 64'h7FF7_FFFF_FFFF_FFFF;
    return x;
  endfunction

  task automatic apply_check(input logic [63:0] x, input logic m, input logic q,
                             input string tag);
    logic [2:0]  ec;
    logic [63:0] er;
    logic        ei;
    opnd = x; mode = m; qreq = q;
    @(negedge clk);
    ec = exp_class(x, m);
    er = exp_result(x, m, q);
    ei = q && (ec == 3'd5);
    n_checks++;
    if (cls !== ec || res !== er || inv !== ei) begin
      n_fail++;
      $display("FAIL %s op=%h m=%0d q=%0d: class %0d/%0d result %h/%h invalid %0d/%0d",
               tag, x, m, q, cls, ec, res, er, inv, ei);
    end
  endtask

  task automatic check_class_stable(input logic [63:0] x, input logic m);
    logic [2:0] c0;
    opnd = x; mode = m; qreq = 1'b0;
    @(negedge clk);
    c0 = cls;
    qreq = 1'b1;
    @(negedge clk);
    n_checks++;
    if (cls !== c0 || cls !== exp_class(x, m)) begin
      n_fail++;
      $display("FAIL R10 op=%h m=%0d: class %0d with req, %0d without, expected %0d",
               x, m, cls, c0, exp_class(x, m));
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [63:0] x;
    seed = 32'd12345;
    void'($urandom(seed));
    opnd = '0; mode = 1'b0; qreq = 1'b0;
    @(negedge clk);
    // reset-like idle state: zero operand, no request
    apply_check(64'h0, 1'b0, 1'b0, "R1 idle");
    apply_check(64'h8000_0000_0000_0000, 1'b1, 1'b1, "R1 neg zero");
    apply_check(64'h0000_0000_0000_0001, 1'b0, 1'b1, "R2 min subnormal");
    apply_check(64'h800F_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R2 max subnormal");
    apply_check(64'h0010_0000_0000_0000, 1'b0, 1'b1, "R3 min normal");
    apply_check(64'hFFEF_FFFF_FFFF_FFFF, 1'b1, 1'b1, "R3 max normal");
    apply_check(64'h7FF0_0000_0000_0000, 1'b0, 1'b1, "R4 +inf");
    apply_check(64'hFFF0_0000_0000_0000, 1'b1, 1'b1, "R4 -inf");
    apply_check(64'h7FF8_0000_0000_0000, 1'b1, 1'b1, "R5/R9 quiet nan 2008");
    apply_check(64'h7FF8_0000_0000_0000, 1'b0, 1'b1, "R5/R7 snan legacy");
    apply_check(64'hFFF0_0000_0000_0001, 1'b1, 1'b1, "R5/R6 snan 2008 low payload");
    apply_check(64'hFFF0_0000_0000_0001, 1'b0, 1'b1, "R5/R9 qnan legacy");
    apply_check(64'hFFF4_5678_9ABC_DEF0, 1'b1, 1'b1, "R6 payload kept");
    apply_check(64'hFFFC_0000_0000_0000, 1'b0, 1'b1, "R7 legacy sign dropped");
    apply_check(64'hFFFC_0000_0000_0000, 1'b0, 1'b0, "R8 no request");
    apply_check(64'h7FF7_FFFF_FFFF_FFFF, 1'b0, 1'b1, "R7 default is quiet");
    check_class_stable(64'h7FF0_0000_0000_0002, 1'b1);
    check_class_stable(64'h7FFF_0000_0000_0000, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      x = {$urandom(), $urandom()};
      case ($urandom_range(0, 3))
        0: x[62:52] = 11'h7FF;
        1: x[62:52] = 11'h000;
        2: if ($urandom_range(0, 1) == 0) x[50:0] = '0;
        default: ;
      endcase
      apply_check(x, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  "R1-R9 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule